// File: doc/BRIEF.md
# Core Error Retry and Sparing Sequencer

This block is the control sequencer that reacts to hardware error reports coming from a processor core. The core keeps its execution results in a checkpoint buffer that SECDED ECC protects. When the core reports a recoverable error, the sequencer first flushes the pipeline. It then restores the last good checkpoint and reissues the affected instruction. An error seen for the first time is treated as intermittent. If the same error code comes back while that retry is still pending, the fault is treated as solid, and the sequencer asks for the workload to move to a spare core.

An unrecoverable error produces a contained core checkstop. In that case only the partition running on this core is terminated, and the rest of the machine keeps running. A request for a spare when no spare core is free has the same outcome. The pipeline, the ECC codec and the firmware that acts on the checkstop are outside this block. The block also counts how many retries it has issued, and it keeps the cause of the last error it accepted.

States: IDLE, FLUSH, RESTORE, RETRY, SPARE_REQ, CHECKSTOP, DONE. Transitions:
- IDLE→FLUSH on a recoverable error.
- IDLE→CHECKSTOP on an unrecoverable error.
- FLUSH→RESTORE, RESTORE→RETRY and SPARE_REQ→CHECKSTOP each take one cycle.
- RETRY→DONE on a clean completion.
- RETRY→SPARE_REQ on a repeat of the same code.
- RETRY→FLUSH on a different recoverable code.
- DONE→IDLE, or DONE→FLUSH if a new recoverable error arrives in DONE.
- Any state except CHECKSTOP goes to CHECKSTOP on an unrecoverable error.

Top module: `core_recov_seq`

## Requirements
- R1: After reset the machine is in IDLE: every strobe is low, `checkstop_o` and `partition_kill_o` are low, `retry_count_o` is 0, and `last_code_o` and `last_fatal_o` are 0.
- R2: A recoverable error (`err_valid_i`=1, `err_fatal_i`=0) accepted in IDLE makes the strobes appear in this order, each high for exactly one cycle:
  - `flush_o` in the cycle after the accepting edge;
  - `restore_o` in the next cycle;
  - `retry_o` in the cycle after that.
- R3: In RETRY, `retry_done_i` with no error report raises `done_o` for one cycle, and the machine then returns to IDLE. Any later error, including one with the same code, is then treated as a first occurrence and goes to FLUSH.
- R4: In RETRY, a recoverable error whose `err_code_i` equals `last_code_o` is a solid fault. It raises `spare_req_o` for exactly one cycle.
- R5: In RETRY, a recoverable error with a different code restarts the sequence at FLUSH, and the new code is recorded.
- R6: Leaving SPARE_REQ always enters CHECKSTOP. `partition_kill_o` is 0 if `spare_avail_i` was 1 in the SPARE_REQ cycle, and 1 otherwise.
- R7: An unrecoverable error (`err_fatal_i`=1) in any state except CHECKSTOP enters CHECKSTOP on the next cycle with `partition_kill_o`=1. It takes priority over `retry_done_i`.
- R8: Once entered, CHECKSTOP holds `checkstop_o` and `partition_kill_o` until reset. New error reports are ignored and leave `last_code_o` and `last_fatal_o` unchanged.
- R9: `retry_count_o` (4 bits) increases by one on each entry to RETRY and saturates at 15.
- R10: Recoverable errors that arrive in FLUSH, RESTORE or SPARE_REQ are ignored: the sequence goes on and the recorded cause does not change. A recoverable error in DONE starts a new FLUSH.
- R11: Every accepted error report loads `err_code_i` into `last_code_o` and `err_fatal_i` into `last_fatal_o` on the accepting edge. In RETRY, an error report takes priority over `retry_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_valid_i | input | 1 | One-cycle error report |
| err_fatal_i | input | 1 | 1 = unrecoverable error |
| err_code_i | input | CODE_W | Error cause code |
| retry_done_i | input | 1 | Retried instruction completed cleanly |
| spare_avail_i | input | 1 | A spare core can take the workload |
| flush_o | output | 1 | Flush strobe (FLUSH entry) |
| restore_o | output | 1 | Checkpoint restore strobe (RESTORE entry) |
| retry_o | output | 1 | Retry issue strobe (RETRY entry) |
| spare_req_o | output | 1 | Sparing request strobe (SPARE_REQ entry) |
| done_o | output | 1 | Recovery complete strobe (DONE entry) |
| checkstop_o | output | 1 | Core checkstopped (level) |
| partition_kill_o | output | 1 | Checkstop is non-recoverable (level) |
| retry_count_o | output | CNT_W | Saturating count of retries issued |
| last_code_o | output | CODE_W | Code of the last accepted error |
| last_fatal_o | output | 1 | Fatal flag of the last accepted error |

## Verification
The bench aims at the repeated-code decision in RETRY. A design that compares against a stale code would request a spare on an unrelated error, or keep retrying a solid one forever. A design that fails to forget the code after DONE would spare on the first error of a new episode.

It also covers the following corner cases:
- An unrecoverable error arriving in the same cycle as `retry_done_i`: a design with the wrong priority would report DONE instead of checking the core stop.
- Reports arriving in FLUSH, RESTORE and CHECKSTOP: a design that does not ignore them would overwrite the cause or leave the stopped state.
- Counter saturation after sixteen retries: a design without saturation would wrap to zero.

// File: rtl/core_recov_pkg.sv
package core_recov_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FLUSH   = 3'd1,
        ST_RESTORE = 3'd2,
        ST_RETRY   = 3'd3,
        ST_SPARE   = 3'd4,
        ST_STOP    = 3'd5,
        ST_DONE    = 3'd6
    } rcv_state_e;

endpackage

// File: rtl/recov_sat_ctr.sv
module recov_sat_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            count_q <= '0;
        else if (inc_i && count_q != CNT_MAX)
            count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    // R9: once at the top value the count stays there
    p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_q == CNT_MAX) |=> (count_q == CNT_MAX));

    // R9: an increment below the top value adds exactly one
    p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));

    // R9: no change without an increment request
    p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inc_i |=> $stable(count_q));
endmodule

// File: rtl/recov_cause_reg.sv
module recov_cause_reg #(
    parameter int CODE_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              fatal_i,
    output logic [CODE_W-1:0] code_o,
    output logic              fatal_o
);
    logic [CODE_W-1:0] code_q;
    logic              fatal_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q  <= '0;
            fatal_q <= 1'b0;
        end else if (load_i) begin
            code_q  <= code_i;
            fatal_q <= fatal_i;
        end
    end

    assign code_o  = code_q;
    assign fatal_o = fatal_q;

    // R11: a report that the sequencer did not accept leaves the cause untouched
    p_hold_unaccepted_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(code_q) && $stable(fatal_q)));
endmodule

// File: rtl/recov_fsm.sv
module recov_fsm
    import core_recov_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              err_valid_i,
    input  logic              err_fatal_i,
    input  logic [CODE_W-1:0] err_code_i,
    input  logic              retry_done_i,
    input  logic              spare_avail_i,
    input  logic [CODE_W-1:0] held_code_i,
    output logic              accept_o,
    output logic              retry_entry_o,
    output logic              flush_o,
    output logic              restore_o,
    output logic              retry_o,
    output logic              spare_req_o,
    output logic              done_o,
    output logic              checkstop_o,
    output logic              partition_kill_o
);
    rcv_state_e state_q, state_d;
    logic       entered_q;
    logic       kill_q, kill_d;
    logic       fatal_err;

    assign fatal_err = err_valid_i && err_fatal_i;

    // next-state and acceptance decode
    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        kill_d   = kill_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (err_valid_i) begin
                    accept_o = 1'b1;
                    state_d  = err_fatal_i ? ST_STOP : ST_FLUSH;
                    kill_d   = err_fatal_i;
                end else if (state_q == ST_DONE) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FLUSH, ST_RESTORE: begin
                if (fatal_err) begin
                    accept_o = 1'b1;
                    state_d  = ST_STOP;
                    kill_d   = 1'b1;
                end else begin
                    state_d = (state_q == ST_FLUSH) ? ST_RESTORE : ST_RETRY;
                end
            end
            ST_RETRY: begin
                if (err_valid_i) begin
                    accept_o = 1'b1;
                    if (err_fatal_i) begin
                        state_d = ST_STOP;
                        kill_d  = 1'b1;
                    end else if (err_code_i == held_code_i) begin
                        state_d = ST_SPARE;
                    end else begin
                        state_d = ST_FLUSH;
                    end
                end else if (retry_done_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_SPARE: begin
                state_d  = ST_STOP;
                accept_o = fatal_err;
                kill_d   = fatal_err || !spare_avail_i;
            end
            ST_STOP: begin
                state_d = ST_STOP;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            entered_q <= 1'b0;
            kill_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            entered_q <= (state_d != state_q);
            kill_q    <= kill_d;
        end
    end

    assign retry_entry_o = (state_d == ST_RETRY) && (state_q != ST_RETRY);

    // output decode
    always_comb begin
        flush_o          = (state_q == ST_FLUSH);
        restore_o        = (state_q == ST_RESTORE);
        retry_o          = (state_q == ST_RETRY) && entered_q;
        spare_req_o      = (state_q == ST_SPARE);
        done_o           = (state_q == ST_DONE);
        checkstop_o      = (state_q == ST_STOP);
        partition_kill_o = kill_q && (state_q == ST_STOP);
    end

    // R2: flush is followed by restore unless a fatal error stops the core
    p_flush_restore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_o && !fatal_err) |=> restore_o);

    // R2: the retry strobe never lasts two cycles
    p_retry_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_o |=> !retry_o);

    // R4: the sparing request is one cycle and leads into checkstop
    p_spare_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spare_req_o |=> (!spare_req_o && checkstop_o));

    // R7: a fatal report outside checkstop stops the core with partition kill
    p_fatal_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fatal_err && !checkstop_o) |=> (checkstop_o && partition_kill_o));

    // R8: checkstop and its kind are held until reset
    p_stop_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        checkstop_o |=> (checkstop_o && $stable(partition_kill_o)));

    // R8: nothing is accepted while stopped
    p_stop_deaf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        checkstop_o |-> !accept_o);

    // R1: at most one strobe or level at a time
    p_one_phase_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({flush_o, restore_o, retry_o, spare_req_o, done_o, checkstop_o}));
endmodule

// File: rtl/core_recov_seq.sv
module core_recov_seq #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              err_valid_i,
    input  logic              err_fatal_i,
    input  logic [CODE_W-1:0] err_code_i,
    input  logic              retry_done_i,
    input  logic              spare_avail_i,
    output logic              flush_o,
    output logic              restore_o,
    output logic              retry_o,
    output logic              spare_req_o,
    output logic              done_o,
    output logic              checkstop_o,
    output logic              partition_kill_o,
    output logic [CNT_W-1:0]  retry_count_o,
    output logic [CODE_W-1:0] last_code_o,
    output logic              last_fatal_o
);
    logic accept;
    logic retry_entry;

    recov_fsm #(.CODE_W(CODE_W)) fsm_i (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .err_valid_i      (err_valid_i),
        .err_fatal_i      (err_fatal_i),
        .err_code_i       (err_code_i),
        .retry_done_i     (retry_done_i),
        .spare_avail_i    (spare_avail_i),
        .held_code_i      (last_code_o),
        .accept_o         (accept),
        .retry_entry_o    (retry_entry),
        .flush_o          (flush_o),
        .restore_o        (restore_o),
        .retry_o          (retry_o),
        .spare_req_o      (spare_req_o),
        .done_o           (done_o),
        .checkstop_o      (checkstop_o),
        .partition_kill_o (partition_kill_o)
    );

    recov_cause_reg #(.CODE_W(CODE_W)) cause_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (accept),
        .code_i  (err_code_i),
        .fatal_i (err_fatal_i),
        .code_o  (last_code_o),
        .fatal_o (last_fatal_o)
    );

    recov_sat_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (retry_entry),
        .count_o (retry_count_o)
    );

    // R9: each retry strobe follows a counted entry, so the count moved or is saturated
    p_retry_counted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retry_o |-> (retry_count_o != '0));
endmodule

// File: tb/core_recov_seq_tb.sv
`timescale 1ns/1ps
module core_recov_seq_tb_top;
    localparam int CODE_W = 6;
    localparam int CNT_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev = 1'b0, ef = 1'b0, rd = 1'b0, sa = 1'b0;
    logic [CODE_W-1:0] ec = '0;
    logic flush, restore, retry, spare, done, cstop, kill, lfat;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] lcode;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    core_recov_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .err_valid_i(ev), .err_fatal_i(ef),
        .err_code_i(ec), .retry_done_i(rd), .spare_avail_i(sa),
        .flush_o(flush), .restore_o(restore), .retry_o(retry),
        .spare_req_o(spare), .done_o(done), .checkstop_o(cstop),
        .partition_kill_o(kill), .retry_count_o(cnt),
        .last_code_o(lcode), .last_fatal_o(lfat)
    );

    // behavioural reference: 0 idle 1 flush 2 restore 3 retry 4 spare 5 stop 6 done
    int m_st = 0, m_nx;
    bit m_new = 0, m_kill = 0, m_fat = 0;
    int m_cnt = 0, m_code = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_new = 0; m_kill = 0; m_fat = 0; m_cnt = 0; m_code = 0;
        end else begin
            m_nx = m_st;
            if (m_st != 5 && ev && ef) begin
                m_nx = 5; m_kill = 1; m_code = int'(ec); m_fat = 1;
            end else begin
                case (m_st)
                    0: if (ev) begin m_nx = 1; m_code = int'(ec); m_fat = 0; end
                    6: if (ev) begin m_nx = 1; m_code = int'(ec); m_fat = 0; end else m_nx = 0;
                    1: m_nx = 2;
                    2: m_nx = 3;
                    3: if (ev) begin
                           m_nx = (int'(ec) == m_code) ? 4 : 1;
                           m_code = int'(ec); m_fat = 0;
                       end else if (rd) m_nx = 6;
                    4: begin m_nx = 5; m_kill = !sa; end
                    default: m_nx = m_st;
                endcase
            end
            if (m_nx == 3 && m_st != 3 && m_cnt < 15) m_cnt++;
            m_new = (m_nx != m_st);
            m_st  = m_nx;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 flush_o",          int'(flush),   int'(m_st == 1));
            chk("R2 restore_o",        int'(restore), int'(m_st == 2));
            chk("R2 retry_o",          int'(retry),   int'(m_st == 3 && m_new));
            chk("R4 spare_req_o",      int'(spare),   int'(m_st == 4));
            chk("R3 done_o",           int'(done),    int'(m_st == 6));
            chk("R7 checkstop_o",      int'(cstop),   int'(m_st == 5));
            chk("R6 partition_kill_o", int'(kill),    int'(m_st == 5 && m_kill));
            chk("R9 retry_count_o",    int'(cnt),     m_cnt);
            chk("R11 last_code_o",     int'(lcode),   m_code);
            chk("R11 last_fatal_o",    int'(lfat),    int'(m_fat));
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ev = 0; ef = 0; rd = 0; sa = 0; ec = '0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic pulse_err(input int code, input bit fatal);
        ev = 1'b1; ef = fatal; ec = CODE_W'(code);
        cyc();
        ev = 1'b0; ef = 1'b0;
    endtask

    task automatic pulse_done();
        rd = 1'b1;
        cyc();
        rd = 1'b0;
    endtask

    task automatic run_retry(input int code);
        pulse_err(code, 0);
        repeat (3) cyc();
        pulse_done();
        repeat (2) cyc();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 strobes", int'({flush, restore, retry, spare, done, cstop, kill}), 0);
        chk("R1 count", int'(cnt), 0);
        chk("R1 cause", int'(lcode), 0);

        // R2 sequence on first recoverable error
        pulse_err(5, 0);
        chk("R2 flush first", int'(flush), 1);
        cyc(); chk("R2 restore next", int'(restore), 1);
        cyc(); chk("R2 retry next", int'(retry), 1);
        cyc(); chk("R2 retry one cycle", int'(retry), 0);
        // R3 clean completion
        pulse_done();
        chk("R3 done", int'(done), 1);
        cyc(); chk("R3 back to idle", int'(done), 0);
        // R3 same code after DONE is a first occurrence
        pulse_err(5, 0);
        chk("R3 repeat after idle flushes", int'(flush), 1);
        chk("R3 no spare", int'(spare), 0);
        cyc(); cyc();
        // R4 solid fault, R6 spare available
        sa = 1'b1;
        pulse_err(5, 0);
        chk("R4 spare_req", int'(spare), 1);
        cyc();
        chk("R6 checkstop with spare", int'(cstop), 1);
        chk("R6 no kill with spare", int'(kill), 0);
        // R8 reports ignored in checkstop
        pulse_err(9, 0);
        pulse_err(11, 1);
        cyc();
        chk("R8 still stopped", int'(cstop), 1);
        chk("R8 kind held", int'(kill), 0);
        chk("R8 cause unchanged", int'(lcode), 5);
        chk("R8 fatal flag unchanged", int'(lfat), 0);

        do_reset();
        // R10 recoverable report during FLUSH is ignored
        pulse_err(3, 0);
        pulse_err(7, 0);
        chk("R10 restore continues", int'(restore), 1);
        chk("R10 cause kept", int'(lcode), 3);
        cyc();
        // R5 different code in RETRY restarts
        pulse_err(8, 0);
        chk("R5 re-flush", int'(flush), 1);
        chk("R5 new code", int'(lcode), 8);
        cyc(); cyc();
        // R6 solid fault without a spare
        sa = 1'b0;
        pulse_err(8, 0);
        chk("R4 spare_req again", int'(spare), 1);
        pulse_err(8, 0);   // R10 ignored in SPARE_REQ
        chk("R6 checkstop no spare", int'(cstop), 1);
        chk("R6 kill no spare", int'(kill), 1);

        do_reset();
        // R7 fatal in IDLE
        pulse_err(2, 1);
        chk("R7 fatal stops", int'(cstop), 1);
        chk("R7 fatal kills", int'(kill), 1);
        chk("R11 fatal flag", int'(lfat), 1);
        chk("R11 fatal code", int'(lcode), 2);

        do_reset();
        // R7 fatal beats retry_done in RETRY
        pulse_err(4, 0);
        cyc(); cyc();
        rd = 1'b1;
        pulse_err(6, 1);
        rd = 1'b0;
        chk("R7 fatal over done", int'(cstop), 1);
        chk("R7 no done", int'(done), 0);

        do_reset();
        // R10 recoverable error in DONE starts new flush
        pulse_err(1, 0);
        cyc(); cyc();
        pulse_done();
        chk("R3 done strobe", int'(done), 1);
        pulse_err(12, 0);
        chk("R10 error in DONE flushes", int'(flush), 1);
        cyc(); cyc();
        pulse_done();
        cyc();

        do_reset();
        // R9 saturation
        for (int i = 0; i < 16; i++) begin
            run_retry(20 + i);
        end
        chk("R9 saturates at 15", int'(cnt), 15);
        run_retry(40);
        chk("R9 stays at 15", int'(cnt), 15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule